// File: doc/BRIEF.md
# Three-Tap Sliding-Window Averager

This block computes a running mean over a stream of unsigned samples. Each result is the sum of three consecutive samples divided by four; the divisor is four, not three. A three-entry shift queue holds the current window. Once the queue holds three samples, one new sample is enough to move the window forward by one position, so every further result costs a single fetch.

The datapath has no sequencer of its own. An external controller drives one strobe per stage: shift a sample into the queue, capture the three-operand sum, halve the captured sum, capture the halved value as the result, and publish it. A typical period is a sum capture, two halving cycles, a result capture and a publish, repeated once per output. The shift for the next sample may share the sum-capture cycle.

Top module: `tap3_avg`

## Requirements
- R1: A synchronous reset clears every queue entry, the sum register, the result register and `result_o` to zero, and drops `result_valid_o`; a sum, halve, capture and publish sequence with no samples shifted in after reset yields 0.
- R2: On a cycle with `shift_i` high, `sample_i` becomes the newest queue entry and every older entry moves one place back, dropping the oldest. With `shift_i` low the queue keeps its contents however many cycles pass.
- R3: `load_sum_i` captures the sum of all three queue entries into an 18-bit register with no loss of carry, so three samples of 65535 give 196605.
- R4: Each cycle with `div_step_i` high (and `load_sum_i` low) replaces the sum register with itself shifted right by one bit, dropping the low bit; two steps give the sum divided by four, truncated toward zero.
- R5: `load_res_i` captures the low 16 bits of the sum register. A cycle with `store_i` high makes `result_o` equal to that captured value from the next cycle on, with `result_valid_o` high for exactly one cycle per publishing cycle.
- R6: Between publishes, `result_o` holds its last value and `result_valid_o` stays low, whatever the other strobes do.
- R7: When `load_sum_i` and `div_step_i` are both high in one cycle, the sum capture wins and the halving step is dropped.
- R8: After three samples have been shifted in, each further shift advances the window by one sample, so the result sequence is the three-sample sliding mean with one fetch per output.
- R9: When `shift_i` and `load_sum_i` are high in the same cycle, the captured sum uses the window as it was before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | 16 | Unsigned sample to shift into the queue |
| shift_i | input | 1 | Shift `sample_i` into the queue as its newest entry |
| load_sum_i | input | 1 | Capture the three-entry sum |
| div_step_i | input | 1 | Shift the sum register right by one bit |
| load_res_i | input | 1 | Capture the low 16 bits of the sum register as the result |
| store_i | input | 1 | Publish the captured result on `result_o` |
| result_o | output | 16 | Last published average |
| result_valid_o | output | 1 | One-cycle pulse after each publishing cycle |

## Verification
Each strobe acts at the rising edge of the cycle in which it is high, and only the publish strobe reaches the ports. A result therefore appears on `result_o`, with its valid pulse, one edge after the publishing cycle, and the other stages show up only through the value published later. The driver updates its own queue, sum and result model at the same edge the design sees the strobe, and it pushes the expected value when it issues a publish. The monitor samples on the falling edge that follows, pops one entry for every valid pulse, and on all other falling edges checks that the published value has not moved.

// File: rtl/tap3_pkg.sv
package tap3_pkg;

  // One strobe per datapath stage, driven by the external controller.
  typedef struct packed {
    logic shift;
    logic load_sum;
    logic div_step;
    logic load_res;
    logic store;
  } tap3_ctl_t;

  // Action applied to the sum register in a cycle.
  typedef enum logic [1:0] {
    ACC_HOLD  = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_HALVE = 2'd2
  } tap3_acc_op_e;

  function automatic tap3_acc_op_e acc_op(input tap3_ctl_t c);
    if (c.load_sum)      return ACC_LOAD;
    else if (c.div_step) return ACC_HALVE;
    else                 return ACC_HOLD;
  endfunction

endpackage

// File: rtl/tap3_window.sv
module tap3_window #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         shift_en,
  input  logic [DATA_W-1:0]            sample_i,
  output logic [TAPS-1:0][DATA_W-1:0]  taps_o
);

  // Entry 0 is the newest sample, entry TAPS-1 the oldest.
  logic [TAPS-1:0][DATA_W-1:0] q;

  for (genvar k = 0; k < TAPS; k++) begin : g_entry
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)           q[k] <= '0;
        else if (shift_en) q[k] <= sample_i;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)           q[k] <= '0;
        else if (shift_en) q[k] <= q[k-1];
      end
    end
  end

  assign taps_o = q;

  // R2
  win_shift_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (q[0] == $past(sample_i)) && (q[TAPS-1] == $past(q[TAPS-2])));

  // R2
  win_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(q));

endmodule

// File: rtl/tap3_accum.sv
module tap3_accum
  import tap3_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAPS   = 3,
  parameter int SUM_W  = DATA_W + $clog2(TAPS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  tap3_ctl_t                    ctl,
  input  logic [TAPS-1:0][DATA_W-1:0]  taps_i,
  output logic [SUM_W-1:0]             window_sum_o,
  output logic [SUM_W-1:0]             acc_o
);

  localparam logic [SUM_W-1:0] MAX_SUM =
    SUM_W'(TAPS * ((64'd1 << DATA_W) - 64'd1));

  // Single multi-operand adder over all taps.
  function automatic logic [SUM_W-1:0] sum_taps(
    input logic [TAPS-1:0][DATA_W-1:0] t);
    logic [SUM_W-1:0] s;
    s = '0;
    for (int k = 0; k < TAPS; k++) s = s + SUM_W'(t[k]);
    return s;
  endfunction

  // One-bit right shift, low bit dropped.
  function automatic logic [SUM_W-1:0] halve(input logic [SUM_W-1:0] v);
    return {1'b0, v[SUM_W-1:1]};
  endfunction

  logic [SUM_W-1:0] acc_q;
  tap3_acc_op_e     op;

  assign window_sum_o = sum_taps(taps_i);
  assign op           = acc_op(ctl);

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else begin
      unique case (op)
        ACC_LOAD:  acc_q <= window_sum_o;
        ACC_HALVE: acc_q <= halve(acc_q);
        default:   acc_q <= acc_q;
      endcase
    end
  end

  assign acc_o = acc_q;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    acc_q <= MAX_SUM);

  // R3
  sum_load_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.load_sum |=> acc_q == $past(window_sum_o));

  // R4
  halve_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.div_step && !ctl.load_sum) |=> acc_q == ($past(acc_q) >> 1));

  // R7
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.div_step && ctl.load_sum) |=> acc_q == $past(window_sum_o));

endmodule

// File: rtl/tap3_result.sv
module tap3_result #(
  parameter int DATA_W = 16,
  parameter int SUM_W  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_res,
  input  logic              store,
  input  logic [SUM_W-1:0]  acc_i,
  output logic [DATA_W-1:0] result_o,
  output logic              result_valid_o
);

  function automatic logic [DATA_W-1:0] narrow(input logic [SUM_W-1:0] v);
    return v[DATA_W-1:0];
  endfunction

  logic              unused_hi;
  logic [DATA_W-1:0] res_q;
  logic [DATA_W-1:0] out_q;
  logic              vld_q;

  assign unused_hi = ^acc_i[SUM_W-1:DATA_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (load_res) res_q <= narrow(acc_i);
      if (store)    out_q <= res_q;
      vld_q <= store;
    end
  end

  assign result_o       = out_q;
  assign result_valid_o = vld_q;

  // R5
  publish_chk: assert property (@(posedge clk) disable iff (rst)
    store |=> result_valid_o && (result_o == $past(res_q)));

  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    !store |=> !result_valid_o && $stable(result_o));

  // R5
  res_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_res |=> res_q == $past(acc_i[DATA_W-1:0]));

endmodule

// File: rtl/tap3_avg.sv
module tap3_avg
  import tap3_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAPS   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       sample_i,
  input  logic              shift_i,
  input  logic              load_sum_i,
  input  logic              div_step_i,
  input  logic              load_res_i,
  input  logic              store_i,
  output logic [15:0]       result_o,
  output logic              result_valid_o
);

  localparam int SUM_W = DATA_W + $clog2(TAPS);

  tap3_ctl_t                   ctl;
  logic [TAPS-1:0][DATA_W-1:0] taps;
  logic [SUM_W-1:0]            window_sum;
  logic [SUM_W-1:0]            acc;

  assign ctl = '{shift:    shift_i,
                 load_sum: load_sum_i,
                 div_step: div_step_i,
                 load_res: load_res_i,
                 store:    store_i};

  tap3_window #(.DATA_W(DATA_W), .TAPS(TAPS)) u_window (
    .clk      (clk),
    .rst      (rst),
    .shift_en (ctl.shift),
    .sample_i (DATA_W'(sample_i)),
    .taps_o   (taps)
  );

  tap3_accum #(.DATA_W(DATA_W), .TAPS(TAPS), .SUM_W(SUM_W)) u_accum (
    .clk          (clk),
    .rst          (rst),
    .ctl          (ctl),
    .taps_i       (taps),
    .window_sum_o (window_sum),
    .acc_o        (acc)
  );

  logic [DATA_W-1:0] res_w;

  tap3_result #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_result (
    .clk            (clk),
    .rst            (rst),
    .load_res       (ctl.load_res),
    .store          (ctl.store),
    .acc_i          (acc),
    .result_o       (res_w),
    .result_valid_o (result_valid_o)
  );

  assign result_o = 16'(res_w);

  // R9
  pre_shift_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (load_sum_i && shift_i) |=> acc == SUM_W'($past(taps[0])) +
                                       SUM_W'($past(taps[1])) +
                                       SUM_W'($past(taps[2])));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (result_o == '0) && !result_valid_o);

endmodule

// File: tb/sim_tap3_avg.sv
`timescale 1ns/1ps
module sim_tap3_avg;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sample_i = '0;
  logic        shift_i = 1'b0, load_sum_i = 1'b0, div_step_i = 1'b0;
  logic        load_res_i = 1'b0, store_i = 1'b0;
  logic [15:0] result_o;
  logic        result_valid_o;

  always #2.5 clk = ~clk;

  tap3_avg u0 (
    .clk(clk), .rst(rst), .sample_i(sample_i), .shift_i(shift_i),
    .load_sum_i(load_sum_i), .div_step_i(div_step_i),
    .load_res_i(load_res_i), .store_i(store_i),
    .result_o(result_o), .result_valid_o(result_valid_o)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // Bench's own model: window m_win[0] newest, sum, result.
  int unsigned m_win[3];
  int unsigned m_acc;
  int unsigned m_res;
  int unsigned expq[$];
  string       tagq[$];
  int unsigned last_out = 0;

  task automatic check(input bit ok, input string req,
                       input int unsigned act, input int unsigned exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One controller cycle; model updated at the same edge as the design.
  task automatic cyc(input bit sh, input int unsigned smp, input bit ls,
                     input bit dv, input bit lr, input bit st,
                     input string tag);
    int unsigned nsum;
    shift_i = sh; sample_i = 16'(smp); load_sum_i = ls;
    div_step_i = dv; load_res_i = lr; store_i = st;
    @(posedge clk);
    nsum = m_win[0] + m_win[1] + m_win[2];
    if (st) begin expq.push_back(m_res); tagq.push_back(tag); end
    if (lr) m_res = m_acc % 65536;
    if (ls) m_acc = nsum;
    else if (dv) m_acc = m_acc / 2;
    if (sh) begin m_win[2] = m_win[1]; m_win[1] = m_win[0]; m_win[0] = smp; end
    @(negedge clk);
    shift_i = 0; load_sum_i = 0; div_step_i = 0; load_res_i = 0; store_i = 0;
  endtask

  // Full output period; optional shift of the next sample on the sum cycle.
  task automatic average(input bit sh, input int unsigned smp, input string tag);
    cyc(sh, smp, 1, 0, 0, 0, tag);
    cyc(0, 0, 0, 1, 0, 0, tag);
    cyc(0, 0, 0, 1, 0, 0, tag);
    cyc(0, 0, 0, 0, 1, 0, tag);
    cyc(0, 0, 0, 0, 0, 1, tag);
  endtask

  task automatic push_sample(input int unsigned smp);
    cyc(1, smp, 0, 0, 0, 0, "R2");
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (result_valid_o) begin
        if (expq.size() == 0) begin
          check(0, "R5 unexpected valid", result_o, 0);
        end else begin
          int unsigned e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check(result_o == e, t, result_o, e);
          last_out = e;
        end
      end else begin
        check(result_o == last_out, "R6 hold", result_o, last_out);
      end
    end
  end

  initial begin
    #(20000 * 5);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) m_win[k] = 0;
    m_acc = 0; m_res = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state at the ports
    check(result_o == 0, "R1 result after reset", result_o, 0);
    check(result_valid_o == 0, "R1 valid after reset", result_valid_o, 0);
    // R1: full sequence on an empty queue gives zero
    average(0, 0, "R1 empty window");
    // R8: prime and slide
    push_sample(10); push_sample(20); push_sample(30);
    average(0, 0, "R8 first window");            // 60/4 = 15
    average(1, 40, "R9 overlap shift");           // still 60 -> 15
    average(1, 50, "R8 slide 20,30,40");          // 90/4 = 22
    average(1, 1001, "R8 slide 30,40,50");        // 120/4 = 30
    average(0, 0, "R8 slide 40,50,1001");         // 1091/4 = 272
    // R2: idle cycles with no shift keep window
    repeat (7) cyc(0, 16'hBEEF, 0, 0, 0, 0, "R2");
    average(0, 0, "R2 window held");              // 272 again
    // R3: maximum operands
    push_sample(65535); push_sample(65535); push_sample(65535);
    average(0, 0, "R3 all ones");                 // 196605/4 = 49151
    // R4: truncation
    push_sample(2); push_sample(2); push_sample(3);
    average(0, 0, "R4 truncate 7/4");             // 1
    push_sample(1); push_sample(1); push_sample(1);
    average(0, 0, "R4 truncate 3/4");             // 0
    // R4: single halving step
    push_sample(100); push_sample(100); push_sample(100);
    cyc(0, 0, 1, 0, 0, 0, "R4"); cyc(0, 0, 0, 1, 0, 0, "R4");
    cyc(0, 0, 0, 0, 1, 0, "R4"); cyc(0, 0, 0, 0, 0, 1, "R4 one step"); // 150
    // R7: load and halve together, load wins
    cyc(0, 0, 1, 1, 0, 0, "R7"); cyc(0, 0, 0, 1, 0, 0, "R7");
    cyc(0, 0, 0, 1, 0, 0, "R7"); cyc(0, 0, 0, 0, 1, 0, "R7");
    cyc(0, 0, 0, 0, 0, 1, "R7 load priority");    // 75
    // R5: back-to-back publishes, one pulse each
    cyc(0, 0, 0, 0, 0, 1, "R5 second publish");
    // R6: load_res without store leaves output alone
    push_sample(9000);
    cyc(0, 0, 1, 0, 0, 0, "R6"); cyc(0, 0, 0, 0, 1, 0, "R6");
    repeat (3) cyc(0, 0, 0, 0, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 1, "R5 late publish");     // 9200 low 16 bits
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R5 all results seen", expq.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule